// File: doc/BRIEF.md
# SPI Block Slave Bridge

This block lets an external SPI master move short blocks of process data into and out of a data broker. The broker holds two byte-wide register areas. The master fills the input area and drains the output area. Each block starts with a four-byte header: a command, a 16-bit zero-based address sent high byte first, and a length. The data bytes follow. A ready line paces whole blocks. While it is low the slave is idle and the master may raise the active-high select. The slave then drives ready high, and the master clocks the block. When select falls, the slave records the outcome and drops ready again. The outcome comes back as the first MISO byte of the following block.

The SPI pins are brought into the system clock domain by two-flop synchronisers, so the system clock must run at least four times faster than the SPI clock. Clock polarity and phase come from two static configuration inputs. Bits always travel MSB first in both directions.

The broker side fills the output area through a valid/ready write stream. Ready is held low for as long as a block is in progress. A write offered during that time stays pending: valid, address and data must remain stable until ready is seen high, and the write lands on that clock edge. Because of this rule, all bytes read in one block come from the same contents of the output area. The input area is read by the broker through a plain combinational read port.

Top module: `spi_block_slave`

## Requirements
- R1: After reset `spi_rdy` is low, `oa_wr_ready` is high, both areas read 0x00, and the first block clocks out status 0x00 on MISO.
- R2: After `spi_sel` goes high, `spi_rdy` rises within a few system clocks and stays high until select falls; after select falls, `spi_rdy` returns low.
- R3: A block with command 0x01 and address 0x1000+k writes its data bytes, received MSB first, to input-area offsets k, k+1, and so on; the broker read port returns them.
- R4: A block with command 0x02 and address 0x2000+k returns output-area bytes k, k+1, and so on, MSB first on MISO during its data bytes. MISO carries 0x00 during header bytes 1 to 3.
- R5: The first MISO byte of every block is the status of the previous block. The status is one-hot: 0x01 complete and OK, 0x02 address or length rejected, 0x04 unknown command, 0x08 incomplete.
- R6: A block is rejected with status 0x02 and writes nothing if any of these holds: its address lies outside the area the command targets, its offset plus length exceeds 256, or its length is 0 or greater than 32.
- R7: A command byte other than 0x01 or 0x02 writes nothing and yields status 0x04.
- R8: If select falls before the header and all declared data bytes have arrived, the bytes already written stay written and the status is 0x08.
- R9: All four SPI modes work, selected by `cfg_cpol` and `cfg_cpha`. Data is sampled on the leading edge when CPHA is 0 and on the trailing edge when CPHA is 1.
- R10: While `spi_rdy` is high, `oa_wr_ready` is low and a pending output-area write is held. The write completes after the block ends, so a read block sees the contents as they were before it began.
- R11: Data bytes beyond the declared length are ignored and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SPI clock idle level |
| cfg_cpha | input | 1 | SPI sample edge: 0 leading, 1 trailing |
| spi_sck | input | 1 | SPI clock from master |
| spi_sel | input | 1 | Active-high block select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_rdy | output | 1 | Block handshake: low idle/status ready, high transfer open |
| oa_wr_valid | input | 1 | Output-area write request |
| oa_wr_ready | output | 1 | Output-area write accepted |
| oa_wr_addr | input | 8 | Output-area write offset |
| oa_wr_data | input | 8 | Output-area write byte |
| ia_rd_addr | input | 8 | Input-area read offset |
| ia_rd_data | output | 8 | Input-area read byte |

## Verification
The hardest case to reach from the pins is a broker write that arrives while a read block is open. If the write landed at once, the bytes returned mid-block would mix old and new contents. The bench forks a read block together with a write to an offset inside that block's window, timed to start once `spi_rdy` is high. It expects the old byte in the open block and the new byte in the next one. The aborted block, the oversize tail and the rejected blocks are each followed by a block whose first MISO byte must show the recorded outcome.

// File: rtl/spi_blk_pkg.sv
package spi_blk_pkg;
  localparam logic [7:0] CMD_WR   = 8'h01;
  localparam logic [7:0] CMD_RD   = 8'h02;
  localparam logic [7:0] ST_NONE  = 8'h00;
  localparam logic [7:0] ST_OK    = 8'h01;
  localparam logic [7:0] ST_RANGE = 8'h02;
  localparam logic [7:0] ST_CMD   = 8'h04;
  localparam logic [7:0] ST_SHORT = 8'h08;
  localparam logic [7:0] HDR_BYTES = 8'd4;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_cpol,
  input  logic cfg_cpha,
  input  logic spi_sck,
  input  logic spi_sel,
  input  logic spi_mosi,
  output logic sel_s,
  output logic mosi_s,
  output logic samp_ev,
  output logic shft_ev
);
  logic [2:0] sck_q;
  logic [1:0] sel_q;
  logic [1:0] mosi_q;
  logic       lvl_now, lvl_prev, lead, trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      sel_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      sel_q  <= {sel_q[0], spi_sel};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  // normalise polarity so the leading edge is always a rise
  assign lvl_now  = sck_q[1] ^ cfg_cpol;
  assign lvl_prev = sck_q[2] ^ cfg_cpol;
  assign lead     = lvl_now & ~lvl_prev;
  assign trail    = ~lvl_now & lvl_prev;
  assign samp_ev  = cfg_cpha ? trail : lead;
  assign shft_ev  = cfg_cpha ? lead : trail;
  assign sel_s    = sel_q[1];
  assign mosi_s   = mosi_q[1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       samp_ev,
  input  logic       shft_ev,
  input  logic       mosi_s,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic [2:0] bit_cnt;
  logic [2:0] out_idx;
  logic [6:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      out_idx   <= '0;
      rx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!en) begin
        bit_cnt <= '0;
        out_idx <= '0;
      end else begin
        if (samp_ev) begin
          rx_sh   <= {rx_sh[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh, mosi_s};
          end
        end
        // the shift edge exposes the bit matching the samples taken so far
        if (shft_ev) out_idx <= bit_cnt;
      end
    end
  end

  assign miso = tx_byte[3'd7 - out_idx];

  // R9
  // sample and shift events come from opposite edges and never coincide
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_ev && shft_ev));
endmodule

// File: rtl/reg_area.sv
module reg_area #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/blk_ctrl.sv
module blk_ctrl
  import spi_blk_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter int          MAX_LEN  = 32,
  parameter logic [15:0] IN_BASE  = 16'h1000,
  parameter logic [15:0] OUT_BASE = 16'h2000,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_s,
  input  logic          byte_done,
  input  logic [7:0]    rx_byte,
  input  logic [7:0]    out_rdata,
  output logic [AW-1:0] out_raddr,
  output logic          in_we,
  output logic [AW-1:0] in_waddr,
  output logic [7:0]    in_wdata,
  output logic [7:0]    tx_byte,
  output logic          active
);
  logic [7:0]    cnt_q, cmd_q, len_q, status_q, tx_q;
  logic [15:0]   addr_q;
  logic [AW-1:0] off_q;
  logic          ok_q;

  logic          cmd_known, hdr_ok_c, rd_go, wr_go;
  logic [15:0]   base;
  logic [16:0]   diff;
  logic [7:0]    didx, ridx, fin;
  logic [AW-1:0] off_cur;

  always_comb begin
    cmd_known = (cmd_q == CMD_WR) || (cmd_q == CMD_RD);
    base      = (cmd_q == CMD_WR) ? IN_BASE : OUT_BASE;
    diff      = {1'b0, addr_q} - {1'b0, base};
    // evaluated while the length byte is on rx_byte
    hdr_ok_c  = cmd_known && !diff[16] && (rx_byte != 8'd0) &&
                (rx_byte <= 8'(MAX_LEN)) &&
                (diff + {9'd0, rx_byte} <= 17'(DEPTH));
    didx      = cnt_q - HDR_BYTES;
    ridx      = cnt_q - (HDR_BYTES - 8'd1);
    off_cur   = (cnt_q == HDR_BYTES - 8'd1) ? diff[AW-1:0] : off_q;
    out_raddr = off_cur + AW'(ridx);
    if (cnt_q == HDR_BYTES - 8'd1)
      rd_go = hdr_ok_c && (cmd_q == CMD_RD);
    else
      rd_go = (cnt_q >= HDR_BYTES) && ok_q && (cmd_q == CMD_RD) && (ridx < len_q);
    wr_go = (cnt_q >= HDR_BYTES) && ok_q && (cmd_q == CMD_WR) && (didx < len_q);
    if (cnt_q < HDR_BYTES)  fin = ST_SHORT;
    else if (!cmd_known)    fin = ST_CMD;
    else if (!ok_q)         fin = ST_RANGE;
    else if (didx < len_q)  fin = ST_SHORT;
    else                    fin = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cnt_q    <= '0;
      cmd_q    <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      off_q    <= '0;
      ok_q     <= 1'b0;
      status_q <= ST_NONE;
      tx_q     <= '0;
      in_we    <= 1'b0;
      in_waddr <= '0;
      in_wdata <= '0;
    end else begin
      in_we <= 1'b0;
      if (!active) begin
        if (sel_s) begin
          active <= 1'b1;
          cnt_q  <= '0;
          ok_q   <= 1'b0;
          tx_q   <= status_q;
        end
      end else if (!sel_s) begin
        active   <= 1'b0;
        status_q <= fin;
      end else if (byte_done) begin
        if (cnt_q != 8'hFF) cnt_q <= cnt_q + 8'd1;
        case (cnt_q)
          8'd0: cmd_q <= rx_byte;
          8'd1: addr_q[15:8] <= rx_byte;
          8'd2: addr_q[7:0] <= rx_byte;
          8'd3: begin
            len_q <= rx_byte;
            ok_q  <= hdr_ok_c;
            off_q <= diff[AW-1:0];
          end
          default: ;
        endcase
        if (wr_go) begin
          in_we    <= 1'b1;
          in_waddr <= off_q + AW'(didx);
          in_wdata <= rx_byte;
        end
        tx_q <= rd_go ? out_rdata : 8'h00;
      end
    end
  end

  assign tx_byte = tx_q;

  // R5
  status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(status_q));
  // R5
  status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q));
  // R3
  byte_count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/spi_block_slave.sv
module spi_block_slave #(
  parameter int          AREA_DEPTH = 256,
  parameter int          MAX_LEN    = 32,
  parameter logic [15:0] IN_BASE    = 16'h1000,
  parameter logic [15:0] OUT_BASE   = 16'h2000,
  localparam int AW = $clog2(AREA_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          spi_sck,
  input  logic          spi_sel,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_rdy,
  input  logic          oa_wr_valid,
  output logic          oa_wr_ready,
  input  logic [AW-1:0] oa_wr_addr,
  input  logic [7:0]    oa_wr_data,
  input  logic [AW-1:0] ia_rd_addr,
  output logic [7:0]    ia_rd_data
);
  logic          sel_s, mosi_s, samp_ev, shft_ev;
  logic          byte_done, active, in_we;
  logic [7:0]    rx_byte, tx_byte, out_rdata, in_wdata;
  logic [AW-1:0] out_raddr, in_waddr;

  spi_pin_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sck(spi_sck), .spi_sel(spi_sel), .spi_mosi(spi_mosi),
    .sel_s(sel_s), .mosi_s(mosi_s), .samp_ev(samp_ev), .shft_ev(shft_ev)
  );

  spi_bit_engine u_bits (
    .clk(clk), .rst_n(rst_n), .en(active), .samp_ev(samp_ev),
    .shft_ev(shft_ev), .mosi_s(mosi_s), .tx_byte(tx_byte),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  blk_ctrl #(
    .DEPTH(AREA_DEPTH), .MAX_LEN(MAX_LEN),
    .IN_BASE(IN_BASE), .OUT_BASE(OUT_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .byte_done(byte_done),
    .rx_byte(rx_byte), .out_rdata(out_rdata), .out_raddr(out_raddr),
    .in_we(in_we), .in_waddr(in_waddr), .in_wdata(in_wdata),
    .tx_byte(tx_byte), .active(active)
  );

  reg_area #(.DEPTH(AREA_DEPTH)) u_in_area (
    .clk(clk), .rst_n(rst_n), .we(in_we), .waddr(in_waddr),
    .wdata(in_wdata), .raddr(ia_rd_addr), .rdata(ia_rd_data)
  );

  reg_area #(.DEPTH(AREA_DEPTH)) u_out_area (
    .clk(clk), .rst_n(rst_n), .we(oa_wr_valid && oa_wr_ready),
    .waddr(oa_wr_addr), .wdata(oa_wr_data), .raddr(out_raddr),
    .rdata(out_rdata)
  );

  assign spi_rdy     = active;
  assign oa_wr_ready = !active;

  // R2
  rdy_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_rdy) |-> spi_sel);
endmodule

// File: tb/tb_spi_block_slave.sv
module tb_spi_block_slave;
  localparam int HP = 160;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic       spi_sck = 1'b0, spi_sel = 1'b0, spi_mosi = 1'b0;
  logic       spi_miso, spi_rdy, oa_wr_ready, oa_wr_valid = 1'b0;
  logic [7:0] oa_wr_addr = '0, oa_wr_data = '0, ia_rd_addr = '0, ia_rd_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string      tag_q[$];
  event       byte_ev;
  logic [7:0] tx_b [16];
  logic [7:0] ex_b [16];

  always #10 clk = ~clk;

  spi_block_slave dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sck(spi_sck), .spi_sel(spi_sel), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_rdy(spi_rdy), .oa_wr_valid(oa_wr_valid),
    .oa_wr_ready(oa_wr_ready), .oa_wr_addr(oa_wr_addr),
    .oa_wr_data(oa_wr_data), .ia_rd_addr(ia_rd_addr), .ia_rd_data(ia_rd_data)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor: compares every byte the master received
  initial forever begin
    @(byte_ev);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
    for (int b = 7; b >= 0; b--) begin
      if (!cfg_cpha) begin
        spi_mosi = tb[b]; #HP;
        spi_sck = ~cfg_cpol; rb[b] = spi_miso; #HP;
        spi_sck = cfg_cpol;
      end else begin
        spi_sck = ~cfg_cpol; spi_mosi = tb[b]; #HP;
        spi_sck = cfg_cpol; rb[b] = spi_miso; #HP;
      end
    end
  endtask

  task automatic run_block(input int mode, input int n, input string t0, input string td);
    logic [7:0] r;
    @(negedge clk);
    cfg_cpol = mode[1]; cfg_cpha = mode[0]; spi_sck = mode[1];
    repeat (4) @(negedge clk);
    spi_sel = 1'b1;
    for (int i = 0; i < 50 && !spi_rdy; i++) @(negedge clk);
    check(spi_rdy == 1'b1, "R2 rdy rise", spi_rdy, 1);
    check(oa_wr_ready == 1'b0, "R10 ready low in block", oa_wr_ready, 0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ex_b[i]);
      tag_q.push_back(i == 0 ? t0 : td);
      xfer(tx_b[i], r);
      got_q.push_back(r);
      ->byte_ev;
    end
    #HP;
    spi_sel = 1'b0;
    for (int i = 0; i < 50 && spi_rdy; i++) @(negedge clk);
    check(spi_rdy == 1'b0, "R2 rdy fall", spi_rdy, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic oa_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    oa_wr_valid = 1'b1; oa_wr_addr = a; oa_wr_data = d;
    while (!oa_wr_ready) @(negedge clk);
    @(negedge clk);
    oa_wr_valid = 1'b0;
  endtask

  task automatic ia_check(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    ia_rd_addr = a;
    #1;
    check(ia_rd_data == e, t, ia_rd_data, e);
  endtask

  task automatic set_hdr(input logic [7:0] c, input logic [7:0] ah,
                         input logic [7:0] al, input logic [7:0] ln,
                         input logic [7:0] st);
    tx_b[0] = c; tx_b[1] = ah; tx_b[2] = al; tx_b[3] = ln;
    for (int i = 0; i < 16; i++) ex_b[i] = 8'h00;
    ex_b[0] = st;
    for (int i = 4; i < 16; i++) tx_b[i] = 8'hFF;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_rdy == 1'b0, "R1 rdy after reset", spi_rdy, 0);
    check(oa_wr_ready == 1'b1, "R1 oa ready after reset", oa_wr_ready, 1);
    ia_check(8'h05, 8'h00, "R1 input area clear");

    for (int i = 0; i < 64; i++) oa_write(8'(i), pat(i));

    // write block, mode 0, reset status first
    set_hdr(8'h01, 8'h10, 8'h05, 8'h04, 8'h00);
    tx_b[4] = 8'hA1; tx_b[5] = 8'hB2; tx_b[6] = 8'hC3; tx_b[7] = 8'hD4;
    run_block(0, 8, "R1 first status", "R3 write miso");
    ia_check(8'h05, 8'hA1, "R3 byte0"); ia_check(8'h06, 8'hB2, "R3 byte1");
    ia_check(8'h07, 8'hC3, "R3 byte2"); ia_check(8'h08, 8'hD4, "R3 byte3");

    // read block, mode 1
    set_hdr(8'h02, 8'h20, 8'h03, 8'h05, 8'h01);
    for (int i = 0; i < 5; i++) ex_b[4 + i] = pat(3 + i);
    run_block(1, 9, "R5 ok status", "R4 read data");

    // out-of-range write, mode 2
    set_hdr(8'h01, 8'h10, 8'hFE, 8'h04, 8'h01);
    tx_b[4] = 8'h11; tx_b[5] = 8'h22; tx_b[6] = 8'h33; tx_b[7] = 8'h44;
    run_block(2, 8, "R9 mode2 status", "R9 mode2 data");
    ia_check(8'hFE, 8'h00, "R6 no write fe"); ia_check(8'hFF, 8'h00, "R6 no write ff");

    // unknown command, mode 3
    set_hdr(8'h07, 8'h10, 8'h00, 8'h02, 8'h02);
    tx_b[4] = 8'h55; tx_b[5] = 8'h66;
    run_block(3, 6, "R6 range status", "R7 miso");
    ia_check(8'h00, 8'h00, "R7 no write 0"); ia_check(8'h01, 8'h00, "R7 no write 1");

    // aborted block, mode 0
    set_hdr(8'h01, 8'h10, 8'h20, 8'h06, 8'h04);
    tx_b[4] = 8'h5A; tx_b[5] = 8'hA5;
    run_block(0, 6, "R7 cmd status", "R8 miso");
    ia_check(8'h20, 8'h5A, "R8 kept 0"); ia_check(8'h21, 8'hA5, "R8 kept 1");
    ia_check(8'h22, 8'h00, "R8 untouched");

    // extra bytes past length, mode 0
    set_hdr(8'h01, 8'h10, 8'h40, 8'h02, 8'h08);
    tx_b[4] = 8'hC1; tx_b[5] = 8'hC2; tx_b[6] = 8'hC3; tx_b[7] = 8'hC4;
    run_block(0, 8, "R8 short status", "R11 miso");
    ia_check(8'h40, 8'hC1, "R11 byte0"); ia_check(8'h41, 8'hC2, "R11 byte1");
    ia_check(8'h42, 8'h00, "R11 extra ignored"); ia_check(8'h43, 8'h00, "R11 extra ignored");

    // read block with a broker write arriving mid-block
    set_hdr(8'h02, 8'h20, 8'h08, 8'h04, 8'h01);
    for (int i = 0; i < 4; i++) ex_b[4 + i] = pat(8 + i);
    fork
      run_block(1, 8, "R11 ok status", "R10 snapshot");
      begin
        wait (spi_rdy);
        oa_write(8'd10, 8'hEE);
      end
    join
    set_hdr(8'h02, 8'h20, 8'h0A, 8'h01, 8'h01);
    ex_b[4] = 8'hEE;
    run_block(2, 5, "R5 ok status", "R10 held write landed");

    // read aimed at the input area is rejected
    set_hdr(8'h02, 8'h10, 8'h00, 8'h01, 8'h01);
    run_block(0, 5, "R5 ok status", "R6 rejected read");
    set_hdr(8'h02, 8'h20, 8'h00, 8'h01, 8'h02);
    ex_b[4] = pat(0);
    run_block(3, 5, "R6 range status", "R9 mode3 read");

    // zero length is rejected
    set_hdr(8'h01, 8'h10, 8'h60, 8'h00, 8'h01);
    run_block(1, 5, "R9 ok status", "R6 zero len");
    ia_check(8'h60, 8'h00, "R6 zero len no write");
    set_hdr(8'h02, 8'h20, 8'h00, 8'h01, 8'h02);
    ex_b[4] = pat(0);
    run_block(0, 5, "R6 zero len status", "R4 read");

    finish_run();
  end
endmodule